// File: doc/BRIEF.md
# Condition Code Register with Interrupt Gate

This block keeps the result flags and the interrupt mask of a small 8-bit processor, and decides when an interrupt is handed to the instruction sequencer. Each cycle the sequencer can present an ALU operation class, both ALU operands and the ALU result. The block then updates the half-carry, negative, zero and carry flags in the way that class requires. Separate pulses set or clear the mask bit, so the sequencer can carry out mask instructions.

Hardware interrupt requests are caught in a pending latch. A request that arrives while the mask is set is not lost: it waits in the latch and is taken as soon as the mask clears. A software interrupt request ignores the mask entirely. When both kinds of request compete, the software interrupt is taken first. Taking any interrupt sets the mask in the same cycle that the take pulse appears. All outputs come from registers.

Top module: `ccr_irq_gate`

## Requirements
- R1: Synchronous active-high reset clears H, N, Z and C, sets the mask I, clears the pending latch and both take outputs, so `ccr_o` reads 8'hE8.
- R2: For class ADD (1) and ADC (2), H becomes the carry from bit 3 into bit 4 and C becomes the carry out of bit 7. The carry-in is the current C for ADC and 0 for ADD.
- R3: For class SUB (3) and SBC (4), C becomes the borrow of a - b - bin, where bin is the current C for SBC and 0 for SUB. H is left unchanged.
- R4: For classes 1 to 5, N takes bit 7 of `alu_result` and Z is set exactly when `alu_result` is zero. Class LOGIC (5) leaves H and C unchanged.
- R5: When `op_valid` is low, or the class is NONE (0) or an unused code (6 or 7), all four result flags keep their values.
- R6: `set_mask` sets I and `clr_mask` clears I on the next edge. If both are high, set wins. I is reported at `ccr_o` bit 3.
- R7: A `hw_irq_req` pulse sets the pending latch on the next edge. While I is set the latch holds. On the first edge at which the latch is set and I is clear, `take_hw_o` goes high for one cycle and the latch clears.
- R8: A `swi_req` makes `take_swi_o` high for one cycle on the next edge, whatever the value of I.
- R9: If `swi_req` and a takeable pending hardware request meet at the same edge, only `take_swi_o` fires, and the hardware request stays pending.
- R10: On the edge that raises either take output, I becomes 1. This overrides a `clr_mask` at that edge.
- R11: `ccr_o` is laid out as {3'b111, H, I, N, Z, C}: H at bit 4, I at bit 3, N at bit 2, Z at bit 1 and C at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Flag update strobe for this cycle |
| op_class | input | 3 | 0 none, 1 ADD, 2 ADC, 3 SUB, 4 SBC, 5 LOGIC, 6/7 none |
| opnd_a | input | 8 | First ALU operand |
| opnd_b | input | 8 | Second ALU operand |
| alu_result | input | 8 | ALU result used for N and Z |
| set_mask | input | 1 | Set the interrupt mask |
| clr_mask | input | 1 | Clear the interrupt mask |
| hw_irq_req | input | 1 | Hardware interrupt request pulse |
| swi_req | input | 1 | Software interrupt request |
| ccr_o | output | 8 | Packed condition code register |
| take_hw_o | output | 1 | Take the hardware interrupt (one cycle) |
| take_swi_o | output | 1 | Take the software interrupt (one cycle) |

## Verification
Flag updates, mask changes and the software take are all due one edge after their inputs are sampled. A hardware request takes two edges: the first sets the latch and the second issues the take, and when the request waits on the mask the second edge comes only after `clr_mask` has taken effect. A behavioural model in the bench steps on every rising edge. Every field is compared at the following falling edge, so each result is sampled in exactly the cycle it is due. Directed checks then land on the cycles where the priority and override cases occur.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  typedef enum logic [2:0] {
    OPC_NONE  = 3'd0,
    OPC_ADD   = 3'd1,
    OPC_ADC   = 3'd2,
    OPC_SUB   = 3'd3,
    OPC_SBC   = 3'd4,
    OPC_LOGIC = 3'd5
  } opc_e;

  localparam int CCR_W = 8;
  localparam logic [2:0] CCR_PAD = 3'b111;
endpackage

// File: rtl/ccr_flag_unit.sv
module ccr_flag_unit
  import ccr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_class,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] result,
  output logic              h_o,
  output logic              n_o,
  output logic              z_o,
  output logic              c_o
);
  localparam int HALF_W = DATA_W / 2;

  logic h_q, n_q, z_q, c_q;
  logic is_add, is_sub, upd_nz, use_cin;
  logic [DATA_W:0] sum_w, diff_w, cin_w;
  logic [HALF_W:0] half_w, hcin_w;

  always_comb begin
    is_add  = (op_class == OPC_ADD) || (op_class == OPC_ADC);
    is_sub  = (op_class == OPC_SUB) || (op_class == OPC_SBC);
    upd_nz  = is_add || is_sub || (op_class == OPC_LOGIC);
    use_cin = (op_class == OPC_ADC) || (op_class == OPC_SBC);
    cin_w   = {{DATA_W{1'b0}}, use_cin & c_q};
    hcin_w  = {{HALF_W{1'b0}}, use_cin & c_q};
    sum_w   = {1'b0, opnd_a} + {1'b0, opnd_b} + cin_w;
    diff_w  = {1'b0, opnd_a} - {1'b0, opnd_b} - cin_w;
    half_w  = {1'b0, opnd_a[HALF_W-1:0]} + {1'b0, opnd_b[HALF_W-1:0]} + hcin_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_q <= 1'b0;
      n_q <= 1'b0;
      z_q <= 1'b0;
      c_q <= 1'b0;
    end else if (op_valid && upd_nz) begin
      n_q <= result[DATA_W-1];
      z_q <= (result == '0);
      if (is_add) begin
        h_q <= half_w[HALF_W];
        c_q <= sum_w[DATA_W];
      end else if (is_sub) begin
        c_q <= diff_w[DATA_W];
      end
    end
  end

  assign h_o = h_q;
  assign n_o = n_q;
  assign z_o = z_q;
  assign c_o = c_q;

  // R2, R3, R4: H changes only on add-type operations
  a_r2_h_add_only: assert property (@(posedge clk) disable iff (rst)
    !(op_valid && is_add) |=> $stable(h_q));
  // R4: a zero result raises Z
  a_r4_zero_sets_z: assert property (@(posedge clk) disable iff (rst)
    (op_valid && upd_nz && result == '0) |=> z_q);
  // R5: no strobe, no flag change
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable({h_q, n_q, z_q, c_q}));
endmodule

// File: rtl/ccr_irq_arb.sv
module ccr_irq_arb (
  input  logic clk,
  input  logic rst,
  input  logic hw_irq_req,
  input  logic swi_req,
  input  logic set_mask,
  input  logic clr_mask,
  output logic mask_o,
  output logic take_hw_o,
  output logic take_swi_o
);
  logic mask_q, pend_q, thw_q, tswi_q;
  logic take_hw_c, take_any_c;

  always_comb begin
    take_hw_c  = pend_q && !mask_q && !swi_req;
    take_any_c = take_hw_c || swi_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= 1'b1;
      pend_q <= 1'b0;
      thw_q  <= 1'b0;
      tswi_q <= 1'b0;
    end else begin
      pend_q <= (pend_q && !take_hw_c) || hw_irq_req;
      thw_q  <= take_hw_c;
      tswi_q <= swi_req;
      if (take_any_c || set_mask) mask_q <= 1'b1;
      else if (clr_mask)          mask_q <= 1'b0;
    end
  end

  assign mask_o     = mask_q;
  assign take_hw_o  = thw_q;
  assign take_swi_o = tswi_q;

  // R8: software interrupt always taken next cycle
  a_r8_swi_taken: assert property (@(posedge clk) disable iff (rst)
    swi_req |=> take_swi_o);
  // R7: hardware take only after an unmasked cycle
  a_r7_hw_unmasked: assert property (@(posedge clk) disable iff (rst)
    take_hw_o |-> !$past(mask_q));
  // R7: masked request stays latched
  a_r7_pend_held: assert property (@(posedge clk) disable iff (rst)
    (pend_q && mask_q) |=> pend_q);
  // R9: at most one take per cycle
  a_r9_single_take: assert property (@(posedge clk) disable iff (rst)
    $onehot0({take_hw_o, take_swi_o}));
  // R10: a take leaves the mask set
  a_r10_take_masks: assert property (@(posedge clk) disable iff (rst)
    (take_hw_o || take_swi_o) |-> mask_o);
endmodule

// File: rtl/ccr_irq_gate.sv
module ccr_irq_gate
  import ccr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_class,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              set_mask,
  input  logic              clr_mask,
  input  logic              hw_irq_req,
  input  logic              swi_req,
  output logic [CCR_W-1:0]  ccr_o,
  output logic              take_hw_o,
  output logic              take_swi_o
);
  logic h_w, n_w, z_w, c_w, i_w;

  ccr_flag_unit #(.DATA_W(DATA_W)) i_flags (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_class (op_class),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .result   (alu_result),
    .h_o      (h_w),
    .n_o      (n_w),
    .z_o      (z_w),
    .c_o      (c_w)
  );

  ccr_irq_arb i_arb (
    .clk        (clk),
    .rst        (rst),
    .hw_irq_req (hw_irq_req),
    .swi_req    (swi_req),
    .set_mask   (set_mask),
    .clr_mask   (clr_mask),
    .mask_o     (i_w),
    .take_hw_o  (take_hw_o),
    .take_swi_o (take_swi_o)
  );

  // R11: fixed packing of the register image
  assign ccr_o = {CCR_PAD, h_w, i_w, n_w, z_w, c_w};

  // R6: set_mask wins and shows on bit 3
  a_r6_set_mask: assert property (@(posedge clk) disable iff (rst)
    set_mask |=> ccr_o[3]);
endmodule

// File: tb/test_ccr_irq_gate.sv
module test_ccr_irq_gate;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [2:0] op_class = 3'd0;
  logic [7:0] opnd_a = 8'd0, opnd_b = 8'd0, alu_result = 8'd0;
  logic       set_mask = 1'b0, clr_mask = 1'b0, hw_irq_req = 1'b0, swi_req = 1'b0;
  logic [7:0] ccr_o;
  logic       take_hw_o, take_swi_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  // model state
  bit mH, mI, mN, mZ, mC, mP, mTH, mTS;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccr_irq_gate i_ccr_irq_gate (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_class(op_class),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .alu_result(alu_result),
    .set_mask(set_mask), .clr_mask(clr_mask), .hw_irq_req(hw_irq_req),
    .swi_req(swi_req), .ccr_o(ccr_o), .take_hw_o(take_hw_o),
    .take_swi_o(take_swi_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model, stepped on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      mH = 0; mI = 1; mN = 0; mZ = 0; mC = 0; mP = 0; mTH = 0; mTS = 0;
      cmp_en = 1'b1;
    end else begin
      int ia, ib, cin, s;
      bit tk_h, tk_s;
      ia = opnd_a; ib = opnd_b;
      if (op_valid) begin
        if (op_class == 3'd1 || op_class == 3'd2) begin
          cin = (op_class == 3'd2) ? int'(mC) : 0;
          s = ia + ib + cin;
          mH = ((ia % 16) + (ib % 16) + cin) > 15;
          mC = s > 255;
        end else if (op_class == 3'd3 || op_class == 3'd4) begin
          cin = (op_class == 3'd4) ? int'(mC) : 0;
          mC = (ia - ib - cin) < 0;
        end
        if (op_class >= 3'd1 && op_class <= 3'd5) begin
          mN = alu_result[7];
          mZ = (alu_result == 8'd0);
        end
      end
      tk_s = swi_req;
      tk_h = mP && !mI && !swi_req;
      mP = (mP && !tk_h) || hw_irq_req;
      if (tk_s || tk_h) mI = 1;
      else if (set_mask) mI = 1;
      else if (clr_mask) mI = 0;
      mTH = tk_h; mTS = tk_s;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (cmp_en && !done) begin
      chk(ccr_o[7:5] == 3'b111, "R11 pad bits", ccr_o[7:5], 7);
      chk(ccr_o[4] == mH, "R2 H flag", ccr_o[4], mH);
      chk(ccr_o[0] == mC, "R3 C flag", ccr_o[0], mC);
      chk(ccr_o[2:1] == {mN, mZ}, "R4 N/Z flags", ccr_o[2:1], {mN, mZ});
      chk(ccr_o[3] == mI, "R6 I mask", ccr_o[3], mI);
      chk(take_hw_o == mTH, "R7 take_hw", take_hw_o, mTH);
      chk(take_swi_o == mTS, "R8 take_swi", take_swi_o, mTS);
    end
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle();
    op_valid = 0; op_class = 0; set_mask = 0; clr_mask = 0;
    hw_irq_req = 0; swi_req = 0;
  endtask

  task automatic alu(input int cls, input int a, input int b, input int r);
    @(negedge clk);
    idle();
    op_valid = 1; op_class = cls[2:0];
    opnd_a = a[7:0]; opnd_b = b[7:0]; alu_result = r[7:0];
  endtask

  initial begin
    logic [7:0] snap;
    idle();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ccr_o == 8'hE8, "R1 reset ccr", ccr_o, 8'hE8);
    chk({take_hw_o, take_swi_o} == 2'b00, "R1 reset takes", {take_hw_o, take_swi_o}, 0);
    rst = 0;

    // R2 / R3 / R4 flag patterns
    alu(1, 8'h0F, 8'h01, 8'h10);
    alu(1, 8'hFF, 8'h01, 8'h00);
    alu(2, 8'h10, 8'h20, 8'h31);
    alu(3, 8'h10, 8'h20, 8'hF0);
    alu(4, 8'h20, 8'h1F, 8'h00);
    alu(5, 8'h00, 8'h00, 8'h80);
    alu(6, 8'hFF, 8'hFF, 8'h00);
    @(negedge clk); idle();
    @(negedge clk);
    // R5: strobe low with an add on the operands leaves flags
    snap = ccr_o;
    op_valid = 0; op_class = 3'd1; opnd_a = 8'hFF; opnd_b = 8'hFF; alu_result = 8'h00;
    @(negedge clk);
    chk(ccr_o == snap, "R5 idle hold", ccr_o, snap);
    op_valid = 1; op_class = 3'd7;
    @(negedge clk);
    chk(ccr_o == snap, "R5 unused class", ccr_o, snap);
    idle();

    // R7: masked request held, taken after clear
    hw_irq_req = 1; @(negedge clk); idle();
    repeat (3) @(negedge clk);
    chk(take_hw_o == 1'b0, "R7 masked no take", take_hw_o, 0);
    clr_mask = 1; @(negedge clk); idle();
    @(negedge clk);
    chk(take_hw_o == 1'b1, "R7 take after unmask", take_hw_o, 1);

    // R9: swi against pending hardware request
    hw_irq_req = 1; @(negedge clk); idle();
    clr_mask = 1; @(negedge clk); idle();
    swi_req = 1; @(negedge clk); idle();
    chk({take_swi_o, take_hw_o} == 2'b10, "R9 swi priority", {take_swi_o, take_hw_o}, 2);
    clr_mask = 1; @(negedge clk); idle();
    @(negedge clk);
    chk(take_hw_o == 1'b1, "R9 hw kept pending", take_hw_o, 1);

    // R10: take overrides clr_mask at the same edge
    clr_mask = 1; @(negedge clk); idle();
    hw_irq_req = 1; @(negedge clk); idle();
    clr_mask = 1; @(negedge clk); idle();
    chk(take_hw_o && ccr_o[3], "R10 take sets I", {take_hw_o, ccr_o[3]}, 3);
    // R8 with mask set
    swi_req = 1; @(negedge clk); idle();
    chk(take_swi_o == 1'b1, "R8 swi while masked", take_swi_o, 1);

    // mixed phase
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      op_valid   = ($urandom % 4) != 0;
      op_class   = 3'($urandom % 8);
      opnd_a     = 8'($urandom);
      opnd_b     = 8'($urandom);
      alu_result = (($urandom % 8) == 0) ? 8'h00 : 8'($urandom);
      hw_irq_req = ($urandom % 16) == 0;
      swi_req    = ($urandom % 32) == 0;
      set_mask   = ($urandom % 20) == 0;
      clr_mask   = ($urandom % 6) == 0;
    end
    @(negedge clk); idle();
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule